// File: doc/BRIEF.md
# Receive Lane Bring-Up Sequencer

This block powers up one serial receive lane on its own, with no software stepping the controls one at a time. A single start pulse sets off a fixed sequence. The auxiliary power-down is released first, then the receiver sleep control. Calibration is enabled next, and the sequencer waits for the calibration-done input. After that the receive-data path is enabled and a clock-recovery reset handshake runs. Each gap between two steps is a minimum time in nanoseconds. That time is turned into a clock-cycle count from a clock-period parameter and rounded up, so no gap can be shorter than its minimum.

The clock-recovery handshake keeps the PCS-ready indication low while the recovery loop goes into reset. It raises PCS-ready again while the reset is still held, and it waits a long settle period before it lets the reset go. After that the link-status input is sampled at a fixed interval. If the link is seen up, the sequencer gives a one-cycle done pulse. If the link is still down once the overall link timeout has elapsed, the sequencer stops with its error output set. A second timeout guards the wait for calibration.

Top module: `rx_lane_bringup`

In the requirements below, the cycle counts are written as follows. S = ceil(STEP_NS*1000/CLK_PS), G = ceil(CAL_GAP_NS*1000/CLK_PS), W = ceil(SETTLE_NS*1000/CLK_PS), P = ceil(POLL_NS*1000/CLK_PS), L = ceil(LINK_TO_NS*1000/CLK_PS) and T = ceil(CAL_TO_NS*1000/CLK_PS). Each of them is at least 1. An "edge" is a rising clock edge, and a change "at edge n" is visible on the outputs right after that edge.

## Requirements
- R1: A start accepted at edge n raises busy and drops aux_pd at edge n. rx_sleep drops at edge n+S.
- R2: cal_en rises S+G cycles after the edge that accepted start, which is G cycles after rx_sleep drops.
- R3: If cal_done is sampled high at edge c, data_en rises at edge c+S. phy_rdy is driven low at that same edge.
- R4: cdr_rst rises S cycles after phy_rdy is driven low, while data_en is already high.
- R5: phy_rdy rises S cycles after cdr_rst rises, with cdr_rst still high.
- R6: cdr_rst falls W cycles after phy_rdy rises, with phy_rdy high.
- R7: Let r be the edge at which cdr_rst falls. link_up is sampled only at edges r+P, r+2P and so on. A high sample at edge r+kP with kP <= L gives done at that edge. A high level between sample edges has no effect.
- R8: If link_up is low at the first sample edge r+kP with kP >= L, err rises at that edge, no done is given, and err stays high.
- R9: If cal_done is never sampled high, err rises T cycles after cal_en rises. A high sample at the last edge of that window still counts as success. On this error, data_en, cdr_rst and phy_rdy keep their values.
- R10: done is high for exactly one cycle. busy falls at the same edge at which done or err rises.
- R11: A start while busy has no effect. A start from idle, done or error is accepted, and at that edge it clears err, cal_en and data_en.
- R12: After a synchronous reset, aux_pd and rx_sleep are 1, and cal_en, data_en, cdr_rst, phy_rdy, busy, done and err are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; only sampled while the sequencer is not busy |
| cal_done | input | 1 | Receiver calibration complete |
| link_up | input | 1 | Link status from the PCS |
| aux_pd | output | 1 | Auxiliary receiver power-down (1 = powered down) |
| rx_sleep | output | 1 | Receiver sleep control (1 = asleep) |
| cal_en | output | 1 | Receiver calibration enable |
| data_en | output | 1 | Receive data path enable |
| cdr_rst | output | 1 | Clock-data-recovery reset (1 = held in reset) |
| phy_rdy | output | 1 | PCS ready indication to the lane |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | Sequence failed; held until the next start or reset |

## Verification
The bench sweeps calibration latency against the cycle at which the link comes up, and it checks every gap to the exact cycle. A design that skips the rounding up would make the 52 ns gaps one cycle short. The two timeout boundaries are also hit directly. Calibration finishing on the last cycle of its window must succeed. A link that first comes up exactly at the overall limit must give done and not err. An off-by-one in either guard turns a pass into a failure, or the other way round. The bench also sends a link pulse that falls between two samples, a start in the middle of a run, a rerun from the done state where phy_rdy has to drop before cdr_rst rises, and a reset during the settle period. These catch a sequencer that samples the link every cycle, restarts on a second start, or reverses the ready/reset order.

// File: rtl/lane_bu_pkg.sv
package lane_bu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_AUX_GAP,
        ST_SLEEP_GAP,
        ST_CAL_WAIT,
        ST_DATA_GAP,
        ST_PHYLO_GAP,
        ST_CDR_GAP,
        ST_SETTLE,
        ST_LINK_POLL,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic aux_pd;
        logic rx_sleep;
        logic cal_en;
        logic data_en;
        logic cdr_rst;
        logic phy_rdy;
    } lane_ctl_t;

    localparam lane_ctl_t CTL_OFF = '{aux_pd: 1'b1, rx_sleep: 1'b1, default: 1'b0};

    // Minimum time in ns -> clock cycles, rounded up, never below one.
    function automatic longint unsigned ns_to_cycles(longint unsigned ns, longint unsigned ps);
        longint unsigned c;
        c = (ns * 64'd1000 + ps - 64'd1) / ps;
        return (c == 64'd0) ? 64'd1 : c;
    endfunction

    function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lane_bu_timer.sv
module lane_bu_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rx_lane_bringup.sv
module rx_lane_bringup
    import lane_bu_pkg::*;
#(
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned STEP_NS    = 50,
    parameter int unsigned CAL_GAP_NS = 500,
    parameter int unsigned SETTLE_NS  = 30_000_000,
    parameter int unsigned POLL_NS    = 500_000,
    parameter int unsigned LINK_TO_NS = 1_000_000_000,
    parameter int unsigned CAL_TO_NS  = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cal_done,
    input  logic link_up,
    output logic aux_pd,
    output logic rx_sleep,
    output logic cal_en,
    output logic data_en,
    output logic cdr_rst,
    output logic phy_rdy,
    output logic busy,
    output logic done,
    output logic err
);
    localparam longint unsigned STEP_CYC   = ns_to_cycles(STEP_NS, CLK_PS);
    localparam longint unsigned GAP_CYC    = ns_to_cycles(CAL_GAP_NS, CLK_PS);
    localparam longint unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PS);
    localparam longint unsigned POLL_CYC   = ns_to_cycles(POLL_NS, CLK_PS);
    localparam longint unsigned LINK_CYC   = ns_to_cycles(LINK_TO_NS, CLK_PS);
    localparam longint unsigned CALTO_CYC  = ns_to_cycles(CAL_TO_NS, CLK_PS);
    localparam longint unsigned MAX_CYC    =
        max2(max2(max2(STEP_CYC, GAP_CYC), max2(SETTLE_CYC, POLL_CYC)),
             max2(LINK_CYC, CALTO_CYC));
    localparam int unsigned TW = $clog2(MAX_CYC + 64'd1);

    // Timers reload with N-1 so the next action lands exactly N edges later.
    localparam logic [TW-1:0] LD_STEP   = TW'(STEP_CYC - 64'd1);
    localparam logic [TW-1:0] LD_GAP    = TW'(GAP_CYC - 64'd1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 64'd1);
    localparam logic [TW-1:0] LD_POLL   = TW'(POLL_CYC - 64'd1);
    localparam logic [TW-1:0] LD_LINK   = TW'(LINK_CYC - 64'd1);
    localparam logic [TW-1:0] LD_CALTO  = TW'(CALTO_CYC - 64'd1);

    seq_state_e state_q, state_d;
    lane_ctl_t  ctl_q, ctl_d;
    logic       busy_q, busy_d, done_q, done_d, err_q, err_d;

    logic          step_ld, grd_ld, step_exp, grd_exp;
    logic [TW-1:0] step_val, grd_val;

    lane_bu_timer #(.W(TW)) i_step_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (step_ld),
        .load_val (step_val),
        .expired  (step_exp)
    );

    lane_bu_timer #(.W(TW)) i_guard_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (grd_ld),
        .load_val (grd_val),
        .expired  (grd_exp)
    );

    always_comb begin
        state_d  = state_q;
        ctl_d    = ctl_q;
        busy_d   = busy_q;
        err_d    = err_q;
        done_d   = 1'b0;
        step_ld  = 1'b0;
        step_val = '0;
        grd_ld   = 1'b0;
        grd_val  = '0;
        unique case (state_q)
            ST_IDLE, ST_FAIL: begin
                if (start) begin
                    ctl_d.aux_pd  = 1'b0;
                    ctl_d.cal_en  = 1'b0;
                    ctl_d.data_en = 1'b0;
                    busy_d   = 1'b1;
                    err_d    = 1'b0;
                    step_ld  = 1'b1;
                    step_val = LD_STEP;
                    state_d  = ST_AUX_GAP;
                end
            end
            ST_AUX_GAP: if (step_exp) begin
                ctl_d.rx_sleep = 1'b0;
                step_ld  = 1'b1;
                step_val = LD_GAP;
                state_d  = ST_SLEEP_GAP;
            end
            ST_SLEEP_GAP: if (step_exp) begin
                ctl_d.cal_en = 1'b1;
                grd_ld  = 1'b1;
                grd_val = LD_CALTO;
                state_d = ST_CAL_WAIT;
            end
            ST_CAL_WAIT: begin
                if (cal_done) begin
                    step_ld  = 1'b1;
                    step_val = LD_STEP;
                    state_d  = ST_DATA_GAP;
                end else if (grd_exp) begin
                    busy_d  = 1'b0;
                    err_d   = 1'b1;
                    state_d = ST_FAIL;
                end
            end
            ST_DATA_GAP: if (step_exp) begin
                ctl_d.data_en = 1'b1;
                ctl_d.phy_rdy = 1'b0;
                step_ld  = 1'b1;
                step_val = LD_STEP;
                state_d  = ST_PHYLO_GAP;
            end
            ST_PHYLO_GAP: if (step_exp) begin
                ctl_d.cdr_rst = 1'b1;
                step_ld  = 1'b1;
                step_val = LD_STEP;
                state_d  = ST_CDR_GAP;
            end
            ST_CDR_GAP: if (step_exp) begin
                ctl_d.phy_rdy = 1'b1;
                step_ld  = 1'b1;
                step_val = LD_SETTLE;
                state_d  = ST_SETTLE;
            end
            ST_SETTLE: if (step_exp) begin
                ctl_d.cdr_rst = 1'b0;
                step_ld  = 1'b1;
                step_val = LD_POLL;
                grd_ld   = 1'b1;
                grd_val  = LD_LINK;
                state_d  = ST_LINK_POLL;
            end
            ST_LINK_POLL: if (step_exp) begin
                if (link_up) begin
                    busy_d  = 1'b0;
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else if (grd_exp) begin
                    busy_d  = 1'b0;
                    err_d   = 1'b1;
                    state_d = ST_FAIL;
                end else begin
                    step_ld  = 1'b1;
                    step_val = LD_POLL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_OFF;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
            busy_q  <= busy_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    assign aux_pd   = ctl_q.aux_pd;
    assign rx_sleep = ctl_q.rx_sleep;
    assign cal_en   = ctl_q.cal_en;
    assign data_en  = ctl_q.data_en;
    assign cdr_rst  = ctl_q.cdr_rst;
    assign phy_rdy  = ctl_q.phy_rdy;
    assign busy     = busy_q;
    assign done     = done_q;
    assign err      = err_q;
endmodule

// File: rtl/lane_bu_checker.sv
module lane_bu_checker (
    input logic clk,
    input logic rst,
    input logic aux_pd,
    input logic rx_sleep,
    input logic cal_en,
    input logic data_en,
    input logic cdr_rst,
    input logic phy_rdy,
    input logic busy,
    input logic done,
    input logic err
);
    p_sleep_after_aux_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_sleep) |-> !aux_pd);

    p_cal_after_sleep_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_en) |-> !rx_sleep);

    p_data_after_cal_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(data_en) |-> (cal_en && !phy_rdy));

    p_cdr_with_ready_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cdr_rst) |-> (!phy_rdy && data_en));

    p_ready_under_reset_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_rdy) |-> cdr_rst);

    p_release_with_ready_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cdr_rst) |-> phy_rdy);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (err && $past(err)) |-> ($stable(data_en) && $stable(cdr_rst) && $stable(phy_rdy)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_ends_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || err));

    p_status_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy && (done || err)));
endmodule

bind rx_lane_bringup lane_bu_checker i_lane_bu_checker (
    .clk      (clk),
    .rst      (rst),
    .aux_pd   (aux_pd),
    .rx_sleep (rx_sleep),
    .cal_en   (cal_en),
    .data_en  (data_en),
    .cdr_rst  (cdr_rst),
    .phy_rdy  (phy_rdy),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/test_rx_lane_bringup.sv
module test_rx_lane_bringup;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CLK_PS = 5000;
    localparam int S   = (52 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int G   = (500 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int W   = (2000 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int P   = (1000 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int L   = (5000 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int T   = (3003 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int NEVER = 1 << 30;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, cal_done = 1'b0, link_up = 1'b0;
    logic aux_pd, rx_sleep, cal_en, data_en, cdr_rst, phy_rdy, busy, done, err;

    rx_lane_bringup #(
        .CLK_PS(5000), .STEP_NS(52), .CAL_GAP_NS(500), .SETTLE_NS(2000),
        .POLL_NS(1000), .LINK_TO_NS(5000), .CAL_TO_NS(3003)
    ) i_rx_lane_bringup (
        .clk(clk), .rst(rst), .start(start), .cal_done(cal_done), .link_up(link_up),
        .aux_pd(aux_pd), .rx_sleep(rx_sleep), .cal_en(cal_en), .data_en(data_en),
        .cdr_rst(cdr_rst), .phy_rdy(phy_rdy), .busy(busy), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog: cycle %0d expected below %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // event record
    int t_aux_fall, t_sleep_fall, t_cal_rise, t_cal_fall, t_data, t_phy_fall, t_phy_rise;
    int t_cdr_rise, t_cdr_fall, t_busy, t_busy_fall, t_done, t_err, t_err_fall, t_cd, done_cnt;
    logic p_aux = 1'b1, p_sleep = 1'b1, p_cal = 1'b0, p_data = 1'b0, p_phy = 1'b0;
    logic p_cdr = 1'b0, p_busy = 1'b0, p_err = 1'b0;
    // stimulus models
    int cal_lat = 0, cal_cnt = 0, link_from = NEVER, pulse_a = 1, pulse_b = 0;

    always @(negedge clk) begin
        if (!aux_pd && p_aux) t_aux_fall = cyc;
        if (!rx_sleep && p_sleep) t_sleep_fall = cyc;
        if (cal_en && !p_cal) t_cal_rise = cyc;
        if (!cal_en && p_cal) t_cal_fall = cyc;
        if (data_en && !p_data) t_data = cyc;
        if (!phy_rdy && p_phy) t_phy_fall = cyc;
        if (phy_rdy && !p_phy) t_phy_rise = cyc;
        if (cdr_rst && !p_cdr) t_cdr_rise = cyc;
        if (!cdr_rst && p_cdr) t_cdr_fall = cyc;
        if (busy && !p_busy) t_busy = cyc;
        if (!busy && p_busy) t_busy_fall = cyc;
        if (err && !p_err) t_err = cyc;
        if (!err && p_err) t_err_fall = cyc;
        if (done === 1'b1) begin
            done_cnt++;
            if (t_done < 0) t_done = cyc;
        end
        p_aux = aux_pd; p_sleep = rx_sleep; p_cal = cal_en; p_data = data_en;
        p_phy = phy_rdy; p_cdr = cdr_rst; p_busy = busy; p_err = err;
        // calibration model: done cal_lat cycles after enable is seen
        if (cal_en !== 1'b1) begin
            cal_cnt = 0; cal_done = 1'b0;
        end else begin
            if (cal_cnt >= cal_lat && !cal_done) begin
                cal_done = 1'b1; t_cd = cyc;
            end
            cal_cnt++;
        end
        // link model relative to recovery release
        if (t_cdr_fall >= 0 && cyc >= t_cdr_fall) begin
            link_up = ((cyc - t_cdr_fall) >= link_from) ||
                      ((cyc - t_cdr_fall) >= pulse_a && (cyc - t_cdr_fall) <= pulse_b);
        end else begin
            link_up = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic clear_rec();
        t_aux_fall = -1; t_sleep_fall = -1; t_cal_rise = -1; t_cal_fall = -1; t_data = -1;
        t_phy_fall = -1; t_phy_rise = -1; t_cdr_rise = -1; t_cdr_fall = -1; t_busy = -1;
        t_busy_fall = -1; t_done = -1; t_err = -1; t_err_fall = -1; t_cd = -1; done_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (t_busy_fall >= 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_full(input int lat, input int lfrom, input int pa, input int pb,
                            input bit fresh, input bit extra_start);
        int k;
        if (fresh) do_reset();
        clear_rec();
        cal_lat = lat; link_from = lfrom; pulse_a = pa; pulse_b = pb;
        pulse_start();
        if (extra_start) begin
            repeat (50) @(negedge clk);
            pulse_start();
        end
        wait_end();
        if (fresh) begin
            chk(t_aux_fall == t_busy, "R1 aux release at start", t_aux_fall, t_busy);
            chk(t_sleep_fall - t_aux_fall == S, "R1 sleep gap", t_sleep_fall - t_aux_fall, S);
        end
        chk(t_cal_rise - t_busy == S + G, extra_start ? "R11 start while busy" : "R2 cal gap",
            t_cal_rise - t_busy, S + G);
        if (lat >= T) begin
            chk(t_err == t_cal_rise + T, "R9 cal timeout", t_err, t_cal_rise + T);
            chk(t_busy_fall == t_err, "R10 busy ends at err", t_busy_fall, t_err);
            chk(t_data < 0 && t_cdr_rise < 0, "R9 controls held", t_data, -1);
            chk(err == 1'b1, "R9 err held", err, 1);
        end else begin
            chk(t_data == t_cd + 1 + S, "R3 data enable gap", t_data, t_cd + 1 + S);
            chk(t_cdr_rise - t_data == S, "R4 cdr reset gap", t_cdr_rise - t_data, S);
            chk(t_phy_rise - t_cdr_rise == S, "R5 ready gap", t_phy_rise - t_cdr_rise, S);
            chk(t_cdr_fall - t_phy_rise == W, "R6 settle", t_cdr_fall - t_phy_rise, W);
            k = (lfrom + P) / P;
            if (k * P <= L) begin
                chk(t_done == t_cdr_fall + k * P, "R7 done at sample", t_done, t_cdr_fall + k * P);
                chk(done_cnt == 1, "R10 done width", done_cnt, 1);
                chk(t_busy_fall == t_done, "R10 busy ends at done", t_busy_fall, t_done);
                chk(t_err < 0, "R7 no err", t_err, -1);
            end else begin
                chk(t_err == t_cdr_fall + L, "R8 link timeout", t_err, t_cdr_fall + L);
                chk(t_done < 0, "R8 no done", t_done, -1);
                chk(t_busy_fall == t_err, "R10 busy ends at err", t_busy_fall, t_err);
                chk(err == 1'b1, "R8 err held", err, 1);
            end
        end
    endtask

    initial begin
        int cal_set[4];
        int lk_set[4];
        cal_set = '{0, 1, 7, T - 1};
        lk_set  = '{0, 250, 4 * P, NEVER};
        clear_rec();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(aux_pd && rx_sleep, "R12 reset power-down", {aux_pd, rx_sleep}, 3);
        chk({cal_en, data_en, cdr_rst, phy_rdy} == 4'b0, "R12 reset enables",
            {cal_en, data_en, cdr_rst, phy_rdy}, 0);
        chk({busy, done, err} == 3'b0, "R12 reset status", {busy, done, err}, 0);

        // sweep calibration latency against link arrival
        foreach (cal_set[i]) foreach (lk_set[j])
            run_full(cal_set[i], lk_set[j], 1, 0, 1'b1, 1'b0);

        // link pulse between samples must be ignored (R7)
        run_full(3, 550, 50, 120, 1'b1, 1'b0);

        // rerun from done with a start while busy (R11, R3)
        run_full(2, 0, 1, 0, 1'b1, 1'b0);
        run_full(5, 0, 1, 0, 1'b0, 1'b1);
        chk(t_cal_fall == t_busy, "R11 cal_en cleared on start", t_cal_fall, t_busy);
        chk(t_phy_fall == t_data, "R3 ready drop with data enable", t_phy_fall, t_data);

        // calibration timeout, one past the last good cycle (R9)
        run_full(T, 0, 1, 0, 1'b1, 1'b0);
        // start from error clears err (R11)
        run_full(4, 0, 1, 0, 1'b0, 1'b0);
        chk(t_err_fall == t_busy, "R11 err cleared on start", t_err_fall, t_busy);

        // reset in the middle of the settle period (R12)
        do_reset();
        clear_rec();
        cal_lat = 2; link_from = 0; pulse_a = 1; pulse_b = 0;
        pulse_start();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (t_phy_rise >= 0) break;
        end
        repeat (5) @(negedge clk);
        chk(cdr_rst && busy, "R12 mid-run state", {cdr_rst, busy}, 3);
        rst = 1'b1;
        @(negedge clk);
        chk(aux_pd && rx_sleep, "R12 mid-run reset power-down", {aux_pd, rx_sleep}, 3);
        chk({cal_en, data_en, cdr_rst, phy_rdy, busy, done, err} == 7'b0,
            "R12 mid-run reset outputs", {cal_en, data_en, cdr_rst, phy_rdy, busy, done, err}, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule